// File: doc/BRIEF.md
# CPU DRAM Access Sequencer with I/O Decode

This block produces the strobe sequence for one processor memory access on a DRAM bus whose address lines are shared between row and column. It runs on a clock at twice the processor rate, so each of its cycles is one half of a processor clock, and a full access spans eight of them. While the access runs it drives the row/column multiplexer select, the row strobe, one column strobe per memory bank and a chip enable for an external peripheral. It also returns an active-low ready to the processor in the last half cycle.

The two upper address bits are decoded to find an I/O region. In that region the row strobe and the multiplexer select still follow the memory timing, but no column strobe fires. Inside the I/O region, an address line that is visible only while the column address is on the DRAM bus picks the target. One value selects the external peripheral, whose enable then follows the column strobe timing. The other value selects an on-block control register, which is written at the point where the column strobe would have fallen.

Top module: `dram_cyc_top`

## Requirements
- R1: During reset and after it, with no request, `row_sel_n`, `ras_n`, every bit of `cas_n`, `perif_cs_n` and `rdy_n` are 1, and `ctrl_reg` is 0.
- R2: A request sampled while idle starts an access. In the first half cycle after that edge, `row_sel_n` is 0 and `ras_n` is 1. In the second half cycle, both are 0.
- R3: `row_sel_n` is 1 from the third half cycle onward. `ras_n` stays 0 through the seventh half cycle. The column strobe is 0 in half cycles four to seven, which begins one half cycle after the switch to column.
- R4: An access lasts exactly eight half cycles, which is four processor clocks. `rdy_n` is 0 only in the eighth, and every strobe is 1 again in the half cycle after that.
- R5: An address whose upper pair (`addr_hi[1]`, `addr_hi[0]`) equals 0,1 is an I/O access. No `cas_n` bit falls, while `row_sel_n` and `ras_n` keep the memory timing. The pairs 0,0, 1,0 and 1,1 are memory accesses.
- R6: In an I/O access where `col_tap` is 1 during the column phase, `perif_cs_n` is 0 in exactly the half cycles where the column strobe would be 0.
- R7: `col_tap` is sampled only in the third half cycle, the first one with the column address on the bus. Its value in any other half cycle does not affect the access.
- R8: An I/O write with `col_tap` at 0 loads `wdata` into `ctrl_reg` at the end of the fourth half cycle. I/O reads, peripheral accesses and memory accesses leave `ctrl_reg` unchanged.
- R9: In a memory access, only `cas_n[bank_sel]` falls. All other bits of `cas_n` stay 1.
- R10: Request, address, bank and data are captured at the start edge. A request raised during an access, and any change of inputs other than `col_tap`, does not alter the access that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the processor rate (one half cycle per edge) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| addr_hi | input | 2 | Upper address pair used for the I/O region decode |
| bank_sel | input | BANK_W | Memory bank whose column strobe is used |
| we | input | 1 | Write access when 1 |
| wdata | input | DATA_W | Write data for the control register |
| col_tap | input | 1 | DRAM address line that carries the register-select bit in the column phase |
| row_sel_n | output | 1 | Multiplexer select, 0 presents the row address |
| ras_n | output | 1 | Row address strobe |
| cas_n | output | NUM_BANKS | Column address strobes, one per bank |
| perif_cs_n | output | 1 | External peripheral chip enable |
| rdy_n | output | 1 | Data-ready to the processor |
| ctrl_reg | output | DATA_W | Internal control register contents |

## Verification
The embedded properties assume that the processor raises `req` only to start an access. They also assume that `col_tap` carries a defined level in the column phase, and that `bank_sel` names an existing bank. The directed stimulus changes inputs only on falling clock edges and pulses `req` for one edge when it starts an access. During the row phase and after the sample point, it drives `col_tap` to the opposite of its column-phase value, so that a sampling error shows up at the outputs. One scenario raises a second request in mid-access and switches the address to the I/O region at the same moment. The properties must hold through that scenario.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
   typedef enum logic {
      ACC_MEM = 1'b0,
      ACC_IO  = 1'b1
   } acc_kind_e;
endpackage

// File: rtl/dram_cyc_seq.sv
module dram_cyc_seq
   import dram_cyc_pkg::*;
#(
   parameter int HALVES = 8,
   parameter int BANK_W = 1,
   parameter int DATA_W = 8,
   parameter logic [1:0] IO_MATCH = 2'b01,
   localparam int PH_W = $clog2(HALVES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [1:0]        addr_hi,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic              active,
   output logic [PH_W-1:0]   phase,
   output acc_kind_e         kind,
   output logic [BANK_W-1:0] bank_q,
   output logic              we_q,
   output logic [DATA_W-1:0] wdata_q
);
   localparam logic [PH_W-1:0] LAST = PH_W'(HALVES - 1);

   logic start;
   assign start = req && !active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         phase   <= '0;
         kind    <= ACC_MEM;
         bank_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
      end else if (start) begin
         active  <= 1'b1;
         phase   <= '0;
         kind    <= (addr_hi == IO_MATCH) ? ACC_IO : ACC_MEM;
         bank_q  <= bank_sel;
         we_q    <= we;
         wdata_q <= wdata;
      end else if (active) begin
         if (phase == LAST) begin
            active <= 1'b0;
            phase  <= '0;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   // R4: an access ends right after its last half cycle
   p_len_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      active && phase == LAST |=> !active);
   // R10: captured request fields hold for the whole access
   p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
      active && $past(active) |-> $stable(kind) && $stable(bank_q) && $stable(wdata_q));
   // R2: every access begins in the first half cycle
   p_start_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> phase == '0);
endmodule

// File: rtl/dram_cyc_iosel.sv
module dram_cyc_iosel
   import dram_cyc_pkg::*;
#(
   parameter int HALVES = 8,
   parameter int COL_AT = 2,
   parameter int CAS_ON = 3,
   parameter int DATA_W = 8,
   parameter logic PERIPH_LEVEL = 1'b1,
   localparam int PH_W = $clog2(HALVES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [PH_W-1:0]   phase,
   input  acc_kind_e         kind,
   input  logic              we_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic              col_tap,
   output logic              to_periph,
   output logic [DATA_W-1:0] ctrl_reg
);
   localparam logic [PH_W-1:0] P_COL = PH_W'(COL_AT);
   localparam logic [PH_W-1:0] P_CAS = PH_W'(CAS_ON);

   logic sel_q;
   logic wr_hit;

   assign to_periph = (sel_q == PERIPH_LEVEL);
   assign wr_hit    = active && phase == P_CAS && kind == ACC_IO && !to_periph && we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= ~PERIPH_LEVEL;
      end else if (active && phase == P_COL) begin
         sel_q <= col_tap;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_reg <= '0;
      end else if (wr_hit) begin
         ctrl_reg <= wdata_q;
      end
   end

   // R7: the select latch moves only in the column sample half cycle
   p_sel_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && phase == P_COL) |=> $stable(sel_q));
   // R8: the register never changes outside an I/O access
   p_reg_io_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && kind == ACC_IO) |=> $stable(ctrl_reg));
endmodule

// File: rtl/dram_cyc_strobe.sv
module dram_cyc_strobe
   import dram_cyc_pkg::*;
#(
   parameter int HALVES    = 8,
   parameter int RAS_AT    = 1,
   parameter int COL_AT    = 2,
   parameter int CAS_ON    = 3,
   parameter int CAS_LAST  = 6,
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = 1,
   localparam int PH_W = $clog2(HALVES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic [PH_W-1:0]      phase,
   input  acc_kind_e            kind,
   input  logic [BANK_W-1:0]    bank_q,
   input  logic                 to_periph,
   output logic                 row_sel_n,
   output logic                 ras_n,
   output logic [NUM_BANKS-1:0] cas_n,
   output logic                 perif_cs_n,
   output logic                 rdy_n
);
   localparam logic [PH_W-1:0] P_RAS  = PH_W'(RAS_AT);
   localparam logic [PH_W-1:0] P_COL  = PH_W'(COL_AT);
   localparam logic [PH_W-1:0] P_CASA = PH_W'(CAS_ON);
   localparam logic [PH_W-1:0] P_CASZ = PH_W'(CAS_LAST);
   localparam logic [PH_W-1:0] P_LAST = PH_W'(HALVES - 1);

   logic cas_win;

   assign cas_win    = active && phase >= P_CASA && phase <= P_CASZ;
   assign row_sel_n  = !(active && phase < P_COL);
   assign ras_n      = !(active && phase >= P_RAS && phase <= P_CASZ);
   assign perif_cs_n = !(cas_win && kind == ACC_IO && to_periph);
   assign rdy_n      = !(active && phase == P_LAST);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cas
      assign cas_n[b] = !(cas_win && kind == ACC_MEM && bank_q == BANK_W'(b));
   end

   // R3: a column strobe only with the column address and the row strobe low
   p_cas_on_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n != '1) |-> row_sel_n && !ras_n);
   // R9: at most one bank strobed
   p_one_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cas_n));
   // R5: an I/O access never strobes a bank
   p_io_no_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active && kind == ACC_IO |-> cas_n == '1);
   // R6: the peripheral enable holds steady across its window
   p_perif_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      active && phase > P_CASA && phase <= P_CASZ && $past(active) |-> $stable(perif_cs_n));
   // R4: ready lasts one half cycle and everything is released after it
   p_rdy_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_n |=> rdy_n && ras_n && row_sel_n && perif_cs_n && cas_n == '1);
   // R1: no strobe while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> row_sel_n && ras_n && rdy_n && perif_cs_n && cas_n == '1);
endmodule

// File: rtl/dram_cyc_top.sv
module dram_cyc_top
   import dram_cyc_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int DATA_W    = 8,
   parameter int ROW_HOLD  = 1,
   parameter int CAS_HOLD  = 4,
   parameter logic [1:0] IO_MATCH = 2'b01,
   parameter logic PERIPH_LEVEL = 1'b1,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [1:0]           addr_hi,
   input  logic [BANK_W-1:0]    bank_sel,
   input  logic                 we,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 col_tap,
   output logic                 row_sel_n,
   output logic                 ras_n,
   output logic [NUM_BANKS-1:0] cas_n,
   output logic                 perif_cs_n,
   output logic                 rdy_n,
   output logic [DATA_W-1:0]    ctrl_reg
);
   localparam int RAS_AT   = 1;
   localparam int COL_AT   = RAS_AT + ROW_HOLD;
   localparam int CAS_ON   = COL_AT + 1;
   localparam int CAS_LAST = CAS_ON + CAS_HOLD - 1;
   localparam int HALVES   = CAS_LAST + 2;
   localparam int PH_W     = $clog2(HALVES);

   if (NUM_BANKS < 2) begin : g_chk_banks
      initial $error("NUM_BANKS must be at least 2");
   end
   if (ROW_HOLD < 1 || CAS_HOLD < 1) begin : g_chk_hold
      initial $error("ROW_HOLD and CAS_HOLD must be at least 1");
   end
   if (DATA_W < 1) begin : g_chk_data
      initial $error("DATA_W must be positive");
   end

   logic              active;
   logic [PH_W-1:0]   phase;
   acc_kind_e         kind;
   logic [BANK_W-1:0] bank_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;
   logic              to_periph;

   dram_cyc_seq #(
      .HALVES(HALVES), .BANK_W(BANK_W), .DATA_W(DATA_W), .IO_MATCH(IO_MATCH)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .addr_hi(addr_hi),
      .bank_sel(bank_sel), .we(we), .wdata(wdata),
      .active(active), .phase(phase), .kind(kind),
      .bank_q(bank_q), .we_q(we_q), .wdata_q(wdata_q)
   );

   dram_cyc_iosel #(
      .HALVES(HALVES), .COL_AT(COL_AT), .CAS_ON(CAS_ON),
      .DATA_W(DATA_W), .PERIPH_LEVEL(PERIPH_LEVEL)
   ) u_iosel (
      .clk(clk), .rst_n(rst_n), .active(active), .phase(phase), .kind(kind),
      .we_q(we_q), .wdata_q(wdata_q), .col_tap(col_tap),
      .to_periph(to_periph), .ctrl_reg(ctrl_reg)
   );

   dram_cyc_strobe #(
      .HALVES(HALVES), .RAS_AT(RAS_AT), .COL_AT(COL_AT), .CAS_ON(CAS_ON),
      .CAS_LAST(CAS_LAST), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
   ) u_strobe (
      .clk(clk), .rst_n(rst_n), .active(active), .phase(phase), .kind(kind),
      .bank_q(bank_q), .to_periph(to_periph),
      .row_sel_n(row_sel_n), .ras_n(ras_n), .cas_n(cas_n),
      .perif_cs_n(perif_cs_n), .rdy_n(rdy_n)
   );
endmodule

// File: tb/dram_cyc_top_tb_top.sv
module dram_cyc_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [1:0] addr_hi = 2'b00;
   logic [0:0] bank_sel = 1'b0;
   logic       we = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       col_tap = 1'b0;
   logic       row_sel_n, ras_n, perif_cs_n, rdy_n;
   logic [1:0] cas_n;
   logic [7:0] ctrl_reg;

   int checks = 0;
   int errors = 0;
   logic [7:0] reg_model = 8'h00;

   always #5 clk = ~clk;

   dram_cyc_top dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .addr_hi(addr_hi),
      .bank_sel(bank_sel), .we(we), .wdata(wdata), .col_tap(col_tap),
      .row_sel_n(row_sel_n), .ras_n(ras_n), .cas_n(cas_n),
      .perif_cs_n(perif_cs_n), .rdy_n(rdy_n), .ctrl_reg(ctrl_reg)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      check({tag, " idle strobes"}, {27'd0, row_sel_n, ras_n, cas_n, perif_cs_n, rdy_n}, 32'h3F);
   endtask

   // one access; col_val is the column-phase tap, the tap carries ~col_val elsewhere
   task automatic run_access(input string tag, input logic [1:0] hi, input logic bank,
                             input logic wr, input logic [7:0] data, input logic col_val,
                             input logic busy_poke);
      logic is_io;
      is_io = (hi == 2'b01);
      @(negedge clk);
      req = 1'b1; addr_hi = hi; bank_sel = bank; we = wr; wdata = data; col_tap = ~col_val;
      for (int p = 0; p < 8; p++) begin
         logic       e_row, e_ras, e_win, e_per, e_rdy;
         logic [1:0] e_cas;
         @(negedge clk);
         if (p == 0) req = 1'b0;
         if (busy_poke && p == 3) begin req = 1'b1; addr_hi = 2'b01; bank_sel = ~bank; end
         if (busy_poke && p == 4) req = 1'b0;
         e_row = (p < 2) ? 1'b0 : 1'b1;                 // R2 R3
         e_ras = (p >= 1 && p <= 6) ? 1'b0 : 1'b1;      // R2 R3
         e_win = (p >= 3 && p <= 6);
         e_cas = (!is_io && e_win) ? ~(2'b01 << bank) : 2'b11;  // R5 R9
         e_per = (is_io && e_win && col_val) ? 1'b0 : 1'b1;     // R6 R7
         e_rdy = (p == 7) ? 1'b0 : 1'b1;                // R4
         check($sformatf("%s R2/R3 row+ras ph%0d", tag, p), {30'd0, row_sel_n, ras_n}, {30'd0, e_row, e_ras});
         check($sformatf("%s R9/R5 cas ph%0d", tag, p), {30'd0, cas_n}, {30'd0, e_cas});
         check($sformatf("%s R6/R7 perif ph%0d", tag, p), {31'd0, perif_cs_n}, {31'd0, e_per});
         check($sformatf("%s R4 rdy ph%0d", tag, p), {31'd0, rdy_n}, {31'd0, e_rdy});
         if (p == 2) col_tap = col_val;
         if (p == 3) col_tap = ~col_val;
      end
      @(negedge clk);
      req = 1'b0;
      check_idle({tag, " R4 after end"});
      if (is_io && wr && !col_val) reg_model = data;
      check({tag, " R8 ctrl_reg"}, {24'd0, ctrl_reg}, {24'd0, reg_model});
   endtask

   task automatic t_reset;
      check_idle("R1 reset");
      check("R1 ctrl_reg reset", {24'd0, ctrl_reg}, 32'd0);
   endtask

   task automatic t_mem;
      run_access("R9 mem bank0", 2'b00, 1'b0, 1'b0, 8'h11, 1'b1, 1'b0);
      run_access("R9 mem bank1", 2'b11, 1'b1, 1'b1, 8'h22, 1'b0, 1'b0);
      run_access("R5 mem hi10", 2'b10, 1'b0, 1'b1, 8'h33, 1'b0, 1'b0);
   endtask

   task automatic t_io;
      run_access("R6 io periph", 2'b01, 1'b0, 1'b0, 8'h44, 1'b1, 1'b0);
      run_access("R8 io reg write", 2'b01, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0);
      run_access("R8 io reg read", 2'b01, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0);
      run_access("R8 io periph write", 2'b01, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0);
      run_access("R7 io reg write2", 2'b01, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0);
   endtask

   task automatic t_busy;
      run_access("R10 busy poke", 2'b00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
      run_access("R10 io after poke", 2'b01, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_mem();
      t_io();
      t_busy();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule